// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits beside a processor that announces each bus cycle with a 3-bit status code instead of driving its own strobes. It watches the code, recognises the moment a new cycle is requested, and walks a four-state bus cycle (T1, T2, T3, T4) with optional wait states. From the state and the latched cycle type it produces the timed strobes that memory, I/O and the interrupt controller need: separate active-low read and write commands for memory and for I/O, an active-low interrupt acknowledge, an address latch enable pulse, a data enable and a data direction level.

A cycle starts on the first clock edge at which the code, having been passive on the previous edge, shows a command type. The type is captured at that edge, so the processor may return the code to passive at any time after T1. Ready is sampled at the end of T3 and of every wait state. While it is low the cycle stays in a wait state with all strobes held.

Top module: `bus_cmd_decoder`

## Requirements
- R1: The status code selects the command: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 100 code fetch (memory read), 101 memory read, 110 memory write. Only the selected command strobe is driven in a cycle.
- R2: A cycle starts only on an edge where the code sampled on the previous edge was 111 and the present code is a command code. A command code held unchanged through and after a cycle does not start a second cycle.
- R3: Codes 011 (halt) and 111 (passive) start no cycle and drive no strobe.
- R4: Address latch enable is high for exactly one clock, the T1 state, which is the clock following the start edge.
- R5: Read, code-fetch and interrupt acknowledge commands are low in T2, T3, every wait state and T4.
- R6: Write commands are low in T3, every wait state and T4, and high in T1 and T2.
- R7: Data enable is high from T2 through T4, wait states included, and low otherwise.
- R8: Data direction is 1 in every state of a write cycle (codes 010 and 110) and 0 in read cycles and when idle.
- R9: Ready low at the end of T3 or of a wait state inserts one more wait state; ready has no effect in T1, T2 and T4.
- R10: While reset is asserted all commands are high and address latch enable, data enable and data direction are 0, whatever the code.
- R11: Every command is high again in the clock after T4, and at most one command is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_status | input | 3 | Cycle type code from the processor |
| ready | input | 1 | High when the addressed device can finish the cycle |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| inta_n | output | 1 | Interrupt acknowledge command, active low |
| ale | output | 1 | Address latch enable, one-clock pulse in T1 |
| den | output | 1 | Data enable, high T2 to T4 |
| dt_tx | output | 1 | Data direction, 1 transmit, 0 receive |

## Verification
The block has no size parameters; its only configuration is the fixed 3-bit code, so the bench builds it as is and sweeps every one of the eight codes. Each command code is run with zero to three wait states, with ready held low during T1, T2 and T4 to show it is ignored there, and each sample is compared against a state-by-state expectation of all eight outputs. Halt, passive, a code held across a cycle and a code driven during reset cover the cases where nothing may happen.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
    localparam int CODE_W = 3;
    localparam int N_CMD  = 5;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t C_INTA    = 3'b000;
    localparam code_t C_IORD    = 3'b001;
    localparam code_t C_IOWR    = 3'b010;
    localparam code_t C_HALT    = 3'b011;
    localparam code_t C_FETCH   = 3'b100;
    localparam code_t C_MRD     = 3'b101;
    localparam code_t C_MWR     = 3'b110;
    localparam code_t C_PASSIVE = 3'b111;

    typedef enum logic [2:0] {
        PH_IDLE, PH_T1, PH_T2, PH_T3, PH_TW, PH_T4
    } phase_t;

    // Command kinds; value k-1 is the index into the command vector.
    typedef enum logic [2:0] {
        K_NONE, K_INTA, K_IORD, K_IOWR, K_MRD, K_MWR
    } kind_t;

    // Bit i set: command i is a write (starts in T3).
    localparam logic [N_CMD-1:0] WR_MASK = 5'b10100;
endpackage

// File: rtl/bsd_classify.sv
module bsd_classify
    import bsd_pkg::*;
(
    input  code_t code,
    output kind_t kind,
    output logic  is_passive
);
    always_comb begin
        is_passive = (code == C_PASSIVE);
        case (code)
            C_INTA:  kind = K_INTA;
            C_IORD:  kind = K_IORD;
            C_IOWR:  kind = K_IOWR;
            C_FETCH: kind = K_MRD;
            C_MRD:   kind = K_MRD;
            C_MWR:   kind = K_MWR;
            default: kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/bsd_seq.sv
module bsd_seq
    import bsd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  kind_t  kind_in,
    input  logic   is_passive,
    input  logic   ready,
    output phase_t phase,
    output kind_t  kind
);
    typedef struct packed {
        phase_t phase;
        kind_t  kind;
        logic   prev_passive;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        nxt_d.prev_passive = is_passive;
        case (cur_q.phase)
            PH_IDLE: begin
                if (cur_q.prev_passive && kind_in != K_NONE) begin
                    nxt_d.phase = PH_T1;
                    nxt_d.kind  = kind_in;
                end
            end
            PH_T1:   nxt_d.phase = PH_T2;
            PH_T2:   nxt_d.phase = PH_T3;
            PH_T3:   nxt_d.phase = ready ? PH_T4 : PH_TW;
            PH_TW:   nxt_d.phase = ready ? PH_T4 : PH_TW;
            PH_T4: begin
                nxt_d.phase = PH_IDLE;
                nxt_d.kind  = K_NONE;
            end
            default: begin
                nxt_d.phase = PH_IDLE;
                nxt_d.kind  = K_NONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.phase        <= PH_IDLE;
            cur_q.kind         <= K_NONE;
            cur_q.prev_passive <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign phase = cur_q.phase;
    assign kind  = cur_q.kind;

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T3 || phase == PH_TW) && !ready) |=> (phase == PH_TW)); // R9
    AST_T4_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T4) |=> (phase == PH_IDLE)); // R11
    AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !cur_q.prev_passive) |=> (phase == PH_IDLE)); // R2
endmodule

// File: rtl/bsd_strobes.sv
module bsd_strobes
    import bsd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase,
    input  kind_t            kind,
    output logic [N_CMD-1:0] cmd_n,
    output logic             ale,
    output logic             den,
    output logic             dt_tx
);
    logic rd_window;
    logic wr_window;

    always_comb begin
        rd_window = (phase == PH_T2) || (phase == PH_T3) ||
                    (phase == PH_TW) || (phase == PH_T4);
        wr_window = (phase == PH_T3) || (phase == PH_TW) || (phase == PH_T4);
        ale       = (phase == PH_T1);
        den       = rd_window;
        dt_tx     = (phase != PH_IDLE) && (kind == K_IOWR || kind == K_MWR);
    end

    for (genvar i = 0; i < N_CMD; i++) begin : g_cmd
        localparam kind_t MY_KIND = kind_t'(i + 1);
        if (WR_MASK[i]) begin : g_wr
            assign cmd_n[i] = !((kind == MY_KIND) && wr_window);
        end else begin : g_rd
            assign cmd_n[i] = !((kind == MY_KIND) && rd_window);
        end
    end

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cmd_n)); // R11
    AST_NO_CMD_IN_T1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (&cmd_n)); // R4
    AST_WR_HAS_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&(cmd_n | ~WR_MASK))) |-> den); // R7
endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
    import bsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_status,
    input  logic       ready,
    output logic       mem_rd_n,
    output logic       mem_wr_n,
    output logic       io_rd_n,
    output logic       io_wr_n,
    output logic       inta_n,
    output logic       ale,
    output logic       den,
    output logic       dt_tx
);
    kind_t            kind_in;
    logic             is_passive;
    phase_t           phase;
    kind_t            kind;
    logic [N_CMD-1:0] cmd_n;

    bsd_classify u_classify (
        .code       (bus_status),
        .kind       (kind_in),
        .is_passive (is_passive)
    );

    bsd_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind_in    (kind_in),
        .is_passive (is_passive),
        .ready      (ready),
        .phase      (phase),
        .kind       (kind)
    );

    bsd_strobes u_strobes (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .kind  (kind),
        .cmd_n (cmd_n),
        .ale   (ale),
        .den   (den),
        .dt_tx (dt_tx)
    );

    assign inta_n   = cmd_n[0];
    assign io_rd_n  = cmd_n[1];
    assign io_wr_n  = cmd_n[2];
    assign mem_rd_n = cmd_n[3];
    assign mem_wr_n = cmd_n[4];

    AST_ALE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && den)); // R4
    AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && !den && (bus_status == C_HALT || bus_status == C_PASSIVE)) |=> !ale); // R3
endmodule

// File: tb/bus_cmd_decoder_bench.sv
module bus_cmd_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] bus_status;
    logic       ready;
    logic       mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n, ale, den, dt_tx;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    bus_cmd_decoder u_bus_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .bus_status(bus_status), .ready(ready),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
        .io_wr_n(io_wr_n), .inta_n(inta_n), .ale(ale), .den(den), .dt_tx(dt_tx)
    );

    // phase numbering: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4
    function automatic logic [7:0] expect_vec(input int code, input int ph);
        logic rdw, wrw;
        rdw = (ph >= 2 && ph <= 5);
        wrw = (ph >= 3 && ph <= 5);
        expect_vec = { !((code == 4 || code == 5) && rdw),
                       !(code == 6 && wrw),
                       !(code == 1 && rdw),
                       !(code == 2 && wrw),
                       !(code == 0 && rdw),
                       (ph == 1),
                       rdw,
                       ((code == 2 || code == 6) && ph != 0) };
    endfunction

    task automatic check(input string tag, input logic [7:0] exp_v);
        logic [7:0] act;
        act = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n, ale, den, dt_tx};
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp_v, $time);
        end
    endtask

    // One bus cycle of the given code with nwait wait states; hold keeps the code.
    task automatic run_cycle(input int code, input int nwait, input bit hold);
        int ph;
        int w;
        ph = 1;
        w  = 0;
        @(negedge clk);
        bus_status = 3'(code);
        ready = (nwait == 0);
        while (ph != 0) begin
            @(negedge clk);
            // R1 R4 R5 R6 R7 R8 R9: state-by-state strobe pattern
            check($sformatf("R1/R5/R6 code %0d wait %0d phase %0d", code, nwait, ph),
                  expect_vec(code, ph));
            case (ph)
                1: begin
                    if (!hold) bus_status = 3'b111;
                    ph = 2;
                end
                2: ph = 3;
                3, 4: begin
                    if (w < nwait) begin
                        ready = 1'b0;
                        w++;
                        ph = 4;
                    end else begin
                        ready = 1'b1;
                        ph = 5;
                    end
                end
                default: begin
                    ready = 1'b0; // R9: ignored in T4
                    ph = 0;
                end
            endcase
        end
        @(negedge clk);
        check($sformatf("R11 idle after code %0d", code), expect_vec(code, 0));
        ready = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        bus_status = 3'b101;
        ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 reset state", 8'b11111000);
        end
        bus_status = 3'b111;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R5 R6 R7 R8 R9: every command code with 0..3 wait states
        for (int c = 0; c < 8; c++) begin
            if (c == 3 || c == 7) continue;
            for (int nw = 0; nw < 4; nw++) begin
                run_cycle(c, nw, 1'b0);
                @(negedge clk);
            end
        end

        // R3: halt and passive codes start nothing
        @(negedge clk);
        bus_status = 3'b011;
        ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R3 halt code no strobe", expect_vec(3, 0));
        end
        bus_status = 3'b111;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R3 passive code no strobe", expect_vec(7, 0));
        end
        ready = 1'b1;

        // R2: code held through the cycle does not restart it
        run_cycle(6, 1, 1'b1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R2 held code no second cycle", expect_vec(6, 0));
        end
        bus_status = 3'b111;
        @(negedge clk);
        // R2: after passive, the next command code starts at once
        run_cycle(5, 0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule